// File: doc/BRIEF.md
# Control-Flow and Interrupt Sequencer

This block owns the program counter, the stack pointer and the interrupt-enable bit of a small 16-bit processor that uses two-word instructions and word-addressed memory. For every issued instruction it works out the next program counter. Instructions that do not branch, and branches whose condition failed, advance the counter by one instruction. A control-flow instruction carries six modifier bits. One bit picks an absolute or a relative target. One pushes a return address. One pops the target from the stack. One requests a software interrupt. Two bits switch interrupts on or off.

Stack traffic goes to a word-addressed memory through a simple read and write port. Read data comes back one cycle after the request. The stack grows downward: a push writes at SP-1 and a pop reads at SP. While a push or pop sequence is running, the block drops its ready output, and the issuing stage holds the next instruction until ready returns high.

An external interrupt line is sampled at instruction boundaries. It is taken only while interrupts are enabled. Taking it pushes the address of the instruction that was about to run, jumps to the vector and disables interrupts.

Top module: `cfs_seq`

## Requirements
- R1: After reset, pc is 0, sp equals the SP_RST parameter, irq_en is 0, instr_ready is 1 and neither mem_rd nor mem_wr is asserted.
- R2: An accepted instruction with instr_cf=0 or exec_en=0 sets pc to pc+2 one cycle later. It leaves sp and irq_en unchanged and makes no memory access, whatever its modifier bits.
- R3: cf_mods is {J,S,P,I,T1,T0}, with J in bit 5 and T0 in bit 0. An executed control-flow instruction without pop or interrupt sets pc to opnd when J=0, and to pc+opnd (modulo 2^16) when J=1.
- R4: T1T0=10 clears irq_en and T1T0=11 sets it. 00 and 01 leave it unchanged. The I test uses this new value.
- R5: When I=1 and the new irq_en is 1, pc becomes VEC (0), J is ignored and no stack read is made, even with P=1.
- R6: When I=1 and the new irq_en is 0, J, S and P act as if I were 0.
- R7: S=1 writes the return address pc+2 once at address sp-1 and leaves sp decremented by one.
- R8: P=1 (with no interrupt taken) reads once at address sp. It uses the returned word in place of opnd for the J=0/J=1 target and leaves sp incremented by one.
- R9: With S=1 and P=1, the read comes before the write and both use the same address. The return address lands in the freed slot and sp ends unchanged.
- R10: While irq_en=1 and hw_irq=1 at an instruction boundary, instr_ready is 0 and no instruction is accepted. The block writes the current pc at sp-1, decrements sp, sets pc to 0 and clears irq_en. With irq_en=0, hw_irq has no effect.
- R11: instr_ready stays low for exactly 2·P + S cycles after an executed control-flow instruction (P counted only when no interrupt is taken), and pc holds until the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | An instruction is issued this cycle |
| instr_cf | input | 1 | The issued instruction is a control-flow instruction |
| exec_en | input | 1 | Condition gate result; 0 turns the instruction into a plain step |
| cf_mods | input | 6 | Modifier bits {J,S,P,I,T1,T0} |
| opnd | input | 16 | Register operand used as jump value |
| hw_irq | input | 1 | External interrupt request level |
| mem_rdata | input | 16 | Stack read data, valid the cycle after mem_rd |
| instr_ready | output | 1 | Block accepts an instruction this cycle |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| irq_en | output | 1 | Interrupt-enable bit |
| mem_rd | output | 1 | Stack read request |
| mem_wr | output | 1 | Stack write request |
| mem_addr | output | 16 | Stack word address |
| mem_wdata | output | 16 | Stack write data |

## Verification
The assertions assume that the stack memory returns read data exactly one cycle after mem_rd. They also assume that the issuing stage offers instructions only while instr_ready is high, so that an instruction is never dropped during a push or pop. The bench's memory model is a one-cycle registered array, and the bench raises instr_valid for a single accepted cycle and then waits for ready to return. The sweep covers all 64 modifier patterns with interrupts both on and off, and with forward and backward relative values. The external interrupt line is raised only at instruction boundaries and is held until the take has started.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WT, ST_WR} cfs_state_e;

  typedef struct packed {
    logic       rel;
    logic       push;
    logic       pop;
    logic       swi;
    logic [1:0] tog;
  } cfs_mods_t;

  function automatic logic irq_after_toggle(input logic [1:0] tog, input logic cur);
    return tog[1] ? tog[0] : cur;
  endfunction
endpackage

// File: rtl/cfs_rst_sync.sv
module cfs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/cfs_decode.sv
module cfs_decode
  import cfs_pkg::*;
(
  input  logic [5:0] mods,
  input  logic       irq_en_cur,
  output logic       rel,
  output logic       push,
  output logic       pop,
  output logic       en_next,
  output logic       swi_take
);
  cfs_mods_t m;

  always_comb begin
    m        = cfs_mods_t'(mods);
    rel      = m.rel;
    push     = m.push;
    // toggle first, then interrupt test on the new enable
    en_next  = irq_after_toggle(m.tog, irq_en_cur);
    swi_take = m.swi & en_next;
    pop      = m.pop & ~swi_take;
  end
endmodule

// File: rtl/cfs_target.sv
module cfs_target #(
  parameter int W = 16
) (
  input  logic         rel,
  input  logic [W-1:0] base,
  input  logic [W-1:0] val,
  output logic [W-1:0] tgt
);
  always_comb begin
    tgt = rel ? (base + val) : val;
  end
endmodule

// File: rtl/cfs_seq.sv
module cfs_seq
  import cfs_pkg::*;
#(
  parameter int W      = 16,
  parameter int STEP   = 2,
  parameter int VEC    = 0,
  parameter int SP_RST = 16'hFF00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instr_valid,
  input  logic         instr_cf,
  input  logic         exec_en,
  input  logic [5:0]   cf_mods,
  input  logic [W-1:0] opnd,
  input  logic         hw_irq,
  input  logic [W-1:0] mem_rdata,
  output logic         instr_ready,
  output logic [W-1:0] pc,
  output logic [W-1:0] sp,
  output logic         irq_en,
  output logic         mem_rd,
  output logic         mem_wr,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata
);
  localparam logic [W-1:0] STEP_W = W'(STEP);
  localparam logic [W-1:0] VEC_W  = W'(VEC);
  localparam logic [W-1:0] SP0_W  = W'(SP_RST);
  localparam logic [W-1:0] ONE_W  = W'(1);

  logic srst_n;

  cfs_state_e st_q, st_n;
  logic [W-1:0] pc_q, pc_n, sp_q, sp_n, ret_q, ret_n, tgt_q, tgt_n;
  logic         en_q, en_n, rel_q, rel_n, push_q, push_n;
  logic         lat_en;
  logic         st_idle;
  logic         take_hw;

  logic         d_rel, d_push, d_pop, d_en, d_swi;
  logic         t_rel;
  logic [W-1:0] t_val, t_tgt;

  cfs_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cfs_decode u_dec (
    .mods       (cf_mods),
    .irq_en_cur (en_q),
    .rel        (d_rel),
    .push       (d_push),
    .pop        (d_pop),
    .en_next    (d_en),
    .swi_take   (d_swi)
  );

  cfs_target #(.W(W)) u_tgt (
    .rel  (t_rel),
    .base (pc_q),
    .val  (t_val),
    .tgt  (t_tgt)
  );

  assign st_idle = (st_q == ST_IDLE);
  assign take_hw = en_q & hw_irq;
  assign t_rel   = (st_q == ST_WT) ? rel_q : d_rel;
  assign t_val   = (st_q == ST_WT) ? mem_rdata : opnd;

  always_comb begin
    st_n   = st_q;
    pc_n   = pc_q;
    sp_n   = sp_q;
    en_n   = en_q;
    ret_n  = ret_q;
    tgt_n  = tgt_q;
    rel_n  = rel_q;
    push_n = push_q;
    lat_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (take_hw) begin
          lat_en = 1'b1;
          ret_n  = pc_q;
          tgt_n  = VEC_W;
          en_n   = 1'b0;
          st_n   = ST_WR;
        end else if (instr_valid) begin
          if (!instr_cf || !exec_en) begin
            pc_n = pc_q + STEP_W;
          end else begin
            lat_en = 1'b1;
            en_n   = d_en;
            ret_n  = pc_q + STEP_W;
            rel_n  = d_rel;
            push_n = d_push;
            if (d_swi) begin
              tgt_n = VEC_W;
              if (d_push) st_n = ST_WR;
              else        pc_n = VEC_W;
            end else if (d_pop) begin
              st_n = ST_RD;
            end else if (d_push) begin
              tgt_n = t_tgt;
              st_n  = ST_WR;
            end else begin
              pc_n = t_tgt;
            end
          end
        end
      end
      ST_RD: st_n = ST_WT;
      ST_WT: begin
        sp_n = sp_q + ONE_W;
        if (push_q) begin
          lat_en = 1'b1;
          tgt_n  = t_tgt;
          st_n   = ST_WR;
        end else begin
          pc_n = t_tgt;
          st_n = ST_IDLE;
        end
      end
      ST_WR: begin
        sp_n = sp_q - ONE_W;
        pc_n = tgt_q;
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= ST_IDLE;
      pc_q <= '0;
      sp_q <= SP0_W;
      en_q <= 1'b0;
    end else begin
      st_q <= st_n;
      pc_q <= pc_n;
      sp_q <= sp_n;
      en_q <= en_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ret_q  <= '0;
      tgt_q  <= '0;
      rel_q  <= 1'b0;
      push_q <= 1'b0;
    end else if (lat_en) begin
      ret_q  <= ret_n;
      tgt_q  <= tgt_n;
      rel_q  <= rel_n;
      push_q <= push_n;
    end
  end

  assign instr_ready = st_idle & ~take_hw;
  assign pc          = pc_q;
  assign sp          = sp_q;
  assign irq_en      = en_q;
  assign mem_rd      = (st_q == ST_RD);
  assign mem_wr      = (st_q == ST_WR);
  assign mem_addr    = (st_q == ST_WR) ? (sp_q - ONE_W) : sp_q;
  assign mem_wdata   = ret_q;
endmodule

// File: rtl/cfs_chk.sv
module cfs_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         instr_valid,
  input logic         instr_cf,
  input logic         hw_irq,
  input logic         irq_en,
  input logic         instr_ready,
  input logic         mem_rd,
  input logic         mem_wr,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] pc,
  input logic [W-1:0] sp,
  input logic         in_idle
);
  AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !instr_ready); // R11

  AST_RD_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> $stable(pc) && !mem_rd && !mem_wr); // R11

  AST_POP_BUMPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ##1 (sp == $past(mem_addr, 2) + W'(1))); // R8

  AST_PUSH_SP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (sp == $past(mem_addr))); // R7

  AST_HW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_irq && irq_en) |-> !instr_ready); // R10

  AST_HW_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_irq && irq_en && in_idle) |=> (!irq_en && mem_wr)); // R10

  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_ready && instr_valid && !instr_cf) |=> (pc == $past(pc) + W'(2))); // R2
endmodule

bind cfs_seq cfs_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_cf    (instr_cf),
  .hw_irq      (hw_irq),
  .irq_en      (irq_en),
  .instr_ready (instr_ready),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .mem_addr    (mem_addr),
  .pc          (pc),
  .sp          (sp),
  .in_idle     (st_idle)
);

// File: tb/sim_cfs_seq.sv
`timescale 1ns/1ps
module sim_cfs_seq;
  localparam int W = 16;
  localparam logic [15:0] SPR = 16'h0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0, instr_cf = 1'b0, exec_en = 1'b0, hw_irq = 1'b0;
  logic [5:0]  cf_mods = '0;
  logic [15:0] opnd = '0;
  logic [15:0] mem_rdata;
  logic instr_ready, irq_en, mem_rd, mem_wr;
  logic [15:0] pc, sp, mem_addr, mem_wdata;

  cfs_seq #(.W(W), .STEP(2), .VEC(0), .SP_RST(SPR)) u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_cf(instr_cf),
    .exec_en(exec_en), .cf_mods(cf_mods), .opnd(opnd), .hw_irq(hw_irq),
    .mem_rdata(mem_rdata), .instr_ready(instr_ready), .pc(pc), .sp(sp),
    .irq_en(irq_en), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  always #10 clk = ~clk;

  logic [15:0] mem [256];
  int cyc = 0, nrd = 0, nwr = 0, rd_cyc = 0, wr_cyc = 0;
  logic [15:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) begin
      nrd <= nrd + 1; rd_addr <= mem_addr; rd_cyc <= cyc;
      mem_rdata <= mem[mem_addr[7:0]];
    end
    if (mem_wr) begin
      nwr <= nwr + 1; wr_addr <= mem_addr; wr_data <= mem_wdata; wr_cyc <= cyc;
      mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: act cyc=%0d exp finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  logic [15:0] pc_m, sp_m;
  logic        en_m;

  task automatic run_ins(input logic cf, input logic ex, input logic [5:0] m,
                         input logic [15:0] op, input logic [15:0] pdata);
    logic j, s, p, i, en_e, swi;
    logic [15:0] pc_e, sp_e, val, wa, wd, sp1;
    int nr, nw, busy_e, busy, r0, w0;
    string tag;
    j = m[5]; s = m[4]; p = m[3]; i = m[2];
    nr = 0; nw = 0; busy_e = 0; wa = '0; wd = pc_m + 16'd2; sp_e = sp_m; en_e = en_m;
    if (!cf || !ex) begin
      pc_e = pc_m + 16'd2; tag = "R2";
    end else begin
      en_e = m[1] ? m[0] : en_m;
      swi  = i && en_e;
      if (swi) begin
        pc_e = 16'h0; nw = s; wa = sp_m - 16'd1; sp_e = sp_m - 16'(s); busy_e = s;
        tag = "R5";
      end else begin
        val  = p ? pdata : op;
        pc_e = j ? pc_m + val : val;
        nr = p; sp1 = sp_m + 16'(p); nw = s; wa = sp1 - 16'd1; sp_e = sp1 - 16'(s);
        busy_e = 2 * int'(p) + int'(s);
        tag = i ? "R6" : (p ? "R8" : (s ? "R7" : "R3"));
      end
    end
    mem[sp_m[7:0]] = pdata;
    @(negedge clk);
    chk("R11", "ready before issue", instr_ready, 1);
    r0 = nrd; w0 = nwr;
    instr_valid = 1; instr_cf = cf; exec_en = ex; cf_mods = m; opnd = op;
    @(negedge clk);
    instr_valid = 0;
    busy = 0;
    while (!instr_ready && busy < 10) begin
      @(negedge clk); busy++;
    end
    chk(tag, "pc", pc, pc_e);
    chk(tag, "sp", sp, sp_e);
    chk("R4", "irq_en", irq_en, en_e);
    chk("R11", "busy cycles", busy, busy_e);
    chk(tag, "reads", nrd - r0, nr);
    chk((s && !(i && en_e)) ? "R7" : tag, "writes", nwr - w0, nw);
    if (nr == 1) chk("R8", "read addr", rd_addr, sp_m);
    if (nw == 1) begin
      chk("R7", "write addr", wr_addr, wa);
      chk("R7", "write data", wr_data, wd);
    end
    if (nr == 1 && nw == 1) begin
      chk("R9", "read before write", (wr_cyc > rd_cyc), 1);
      chk("R9", "same slot", wr_addr, rd_addr);
    end
    pc_m = pc_e; sp_m = sp_e; en_m = en_e;
  endtask

  task automatic setup(input logic en, input logic [15:0] at);
    run_ins(1, 1, {4'b0000, 1'b1, en}, at, 16'h0);
  endtask

  initial begin
    int w0, b;
    mem_rdata = '0;
    for (int k = 0; k < 256; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "pc", pc, 0);
    chk("R1", "sp", sp, SPR);
    chk("R1", "irq_en", irq_en, 0);
    chk("R1", "ready", instr_ready, 1);
    chk("R1", "mem idle", {mem_rd, mem_wr}, 0);
    pc_m = 0; sp_m = SPR; en_m = 0;

    for (int e0 = 0; e0 < 2; e0++)
      for (int m = 0; m < 64; m++)
        for (int k = 0; k < 2; k++) begin
          setup(e0[0], 16'h1000 + 16'(m * 16));
          run_ins(1, 1, 6'(m), k ? 16'hFFF0 : 16'h0230 + 16'(m),
                  16'h0400 ^ 16'(m << 3) ^ 16'(k));
        end

    for (int m = 0; m < 64; m++) begin
      setup(m[0], 16'h2000);
      run_ins(0, 1, 6'(m), 16'h1234, 16'h5);
      run_ins(1, 0, 6'(m), 16'h4321, 16'h6);
    end

    // R10 external interrupt taken when enabled
    setup(1, 16'h3456);
    @(negedge clk);
    w0 = nwr;
    hw_irq = 1; instr_valid = 1; instr_cf = 0; exec_en = 1;
    #1 chk("R10", "ready low on irq", instr_ready, 0);
    @(negedge clk);
    hw_irq = 0; instr_valid = 0;
    b = 0;
    while (!instr_ready && b < 10) begin @(negedge clk); b++; end
    chk("R10", "pc vector", pc, 0);
    chk("R10", "sp", sp, sp_m - 16'd1);
    chk("R10", "irq_en cleared", irq_en, 0);
    chk("R10", "one write", nwr - w0, 1);
    chk("R10", "write addr", wr_addr, sp_m - 16'd1);
    chk("R10", "write data", wr_data, 16'h3456);
    chk("R11", "irq busy", b, 1);
    pc_m = 0; sp_m = sp_m - 16'd1; en_m = 0;

    // R10 ignored when disabled
    setup(0, 16'h0777);
    @(negedge clk);
    w0 = nwr;
    hw_irq = 1;
    #1 chk("R10", "ready with irq off", instr_ready, 1);
    repeat (3) @(negedge clk);
    hw_irq = 0;
    chk("R10", "pc held", pc, 16'h0777);
    chk("R10", "no write", nwr - w0, 0);
    chk("R10", "irq_en still 0", irq_en, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule